// File: doc/BRIEF.md
# CBR Refresh and Init Scheduler

This block owns the row and column strobes of an asynchronous DRAM whenever a refresh is due. After reset it keeps both strobes high for the power-up pause. It then runs a burst of CAS-before-RAS refresh cycles that cannot be skipped, and only then lets normal accesses start. After that a free-running interval timer records one refresh as owed every interval. The block asks the access sequencer for the bus and runs the CBR cycle itself once the request is granted. Address and data pins are not used during refresh.

Refreshes that the sequencer does not grant are counted in a small backlog. When the backlog is full, an urgent flag tells the sequencer that it must grant at its next opportunity. If one more interval expires while the backlog is full, a sticky error is raised.

The strobe timing is derived from nanosecond parameters and the clock period. The width of the RAS low pulse is capped below the maximum pulse width, so that a refresh can never slip into self refresh.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n and cas_n are 1, and init_done, refresh_req, refresh_urgent and backlog_err are all 0.
- R2: For PWRUP_CYC = ceil(PWRUP_NS/CLK_NS) cycles after reset is released, both strobes stay high. The first CAS fall is seen in cycle PWRUP_CYC+1, counting the first clock edge after reset as cycle 1.
- R3: After the pause, exactly INIT_REFS CBR cycles run without any grant. Their RAS falls are spaced CSR_CYC+RAS_CYC+RP_CYC+1 cycles apart.
- R4: init_done rises in the cycle after the precharge of the last initialization refresh ends. While init_done is 0, refresh_req stays 0.
- R5: In every refresh, CAS is low for exactly CSR_CYC = max(1, ceil(CSR_NS/CLK_NS)) cycles before RAS falls. CAS stays low for the whole time RAS is low, and it rises in the same cycle as RAS.
- R6: RAS stays low for RAS_CYC = max(ceil(RAS_MIN_NS/CLK_NS), ceil(RC_NS/CLK_NS) - RP_CYC) cycles. This value is clamped to below floor(RAS_MAX_NS/CLK_NS).
- R7: Between the rise of RAS and the next fall of CAS, both strobes stay high for at least RP_CYC = max(1, ceil(RP_NS/CLK_NS)) cycles.
- R8: After init_done, one refresh is owed every INTERVAL_CYC = floor(REF_INTERVAL_NS/CLK_NS) cycles, the first one INTERVAL_CYC cycles after init_done rises. refresh_req is high when a refresh is owed and no refresh cycle is running. A cycle starts only after bus_gnt is sampled high together with refresh_req, and its RAS falls CSR_CYC+1 cycles after that sample.
- R9: Refreshes that are owed but not granted are counted. refresh_urgent is high exactly while the count equals MAX_PEND.
- R10: Once granted, owed refreshes run back to back, one per owed count. After the last one, refresh_req and refresh_urgent are 0.
- R11: An interval that expires while the count is MAX_PEND and no refresh is completing sets backlog_err. backlog_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Access sequencer hands the DRAM bus to refresh |
| refresh_req | output | 1 | A refresh is owed and the scheduler is idle |
| refresh_urgent | output | 1 | Backlog full; grant must be forced |
| ref_active | output | 1 | A refresh cycle owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | Initialization refreshes finished; accesses may start |
| backlog_err | output | 1 | Sticky backlog overflow |

## Verification
The scheduler is driven through four grant patterns, each placed in time against an expected schedule:
- **No grant during initialization** shows that the power-up burst runs on its own and ends with init_done at an exact cycle.
- **Grant held high** shows that each refresh starts at the exact cycle its interval expires.
- **Grant withheld over several intervals, then given** tells a real backlog with back-to-back draining apart from a scheduler that drops refreshes it owes.
- **Grant withheld until one interval past full** separates the urgent state from the sticky overflow error.

Every RAS fall is matched against a queue of expected cycles. The monitor also measures CAS lead, RAS width and precharge on every cycle.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

  typedef enum logic [2:0] {
    S_PWRUP  = 3'd0,
    S_IDLE   = 3'd1,
    S_CSETUP = 3'd2,
    S_RLOW   = 3'd3,
    S_PRECH  = 3'd4
  } cbr_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int bits_for(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // owed-refresh counter update: saturating at cap, never below zero
  function automatic int backlog_next(input int cur, input bit add, input bit sub, input int cap);
    if (add && !sub && cur < cap) return cur + 1;
    if (sub && !add && cur > 0)   return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
`timescale 1ns/1ps
module cbr_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  import cbr_pkg::*;

  localparam int TW = bits_for(INTERVAL_CYC);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cbr_backlog.sv
`timescale 1ns/1ps
module cbr_backlog #(
  parameter int MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic pending,
  output logic urgent,
  output logic overflow_err
);
  import cbr_pkg::*;

  localparam int CW = bits_for(MAX_PEND);
  localparam logic [CW-1:0] FULL = CW'(MAX_PEND);

  logic [CW-1:0] owed;
  logic          ovf_event;

  assign pending   = (owed != '0);
  assign urgent    = (owed == FULL);
  assign ovf_event = tick && !done && (owed == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed         <= '0;
      overflow_err <= 1'b0;
    end else begin
      owed         <= CW'(backlog_next(int'(owed), tick, done, MAX_PEND));
      overflow_err <= overflow_err | ovf_event;
    end
  end

  AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= FULL); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err); // R11

endmodule

// File: rtl/cbr_strobe_fsm.sv
`timescale 1ns/1ps
module cbr_strobe_fsm #(
  parameter int PWRUP_CYC   = 10000,
  parameter int CSR_CYC     = 1,
  parameter int RAS_CYC     = 7,
  parameter int RP_CYC      = 4,
  parameter int RAS_MAX_CYC = 1000,
  parameter int INIT_REFS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic bus_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic ref_active,
  output logic ref_done,
  output logic idle,
  output logic init_done
);
  import cbr_pkg::*;

  localparam int PH_MAX = max_i(max_i(PWRUP_CYC, CSR_CYC), max_i(RAS_CYC, RP_CYC));
  localparam int PW = bits_for(PH_MAX);
  localparam int IW = bits_for(INIT_REFS);
  localparam int RW = bits_for(RAS_MAX_CYC);
  localparam logic [PW-1:0] PWRUP_LAST = PW'(PWRUP_CYC - 1);
  localparam logic [PW-1:0] CSR_LAST   = PW'(CSR_CYC - 1);
  localparam logic [PW-1:0] RAS_LAST   = PW'(RAS_CYC - 1);
  localparam logic [PW-1:0] RP_LAST    = PW'(RP_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_REFS - 1);

  cbr_state_e    st;
  logic [PW-1:0] ph;
  logic [IW-1:0] init_cnt;
  logic          go;
  logic [RW-1:0] ras_lo_run;

  // during init the burst needs no grant; afterwards only a granted request starts
  assign go         = (st == S_IDLE) && (!init_done || (pending && bus_gnt));
  assign idle       = (st == S_IDLE);
  assign ref_active = (st == S_CSETUP) || (st == S_RLOW) || (st == S_PRECH);
  assign ref_done   = (st == S_PRECH) && (ph == RP_LAST);
  assign cas_n      = !((st == S_CSETUP) || (st == S_RLOW));
  assign ras_n      = !(st == S_RLOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWRUP;
      ph        <= '0;
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PWRUP: begin
          if (ph == PWRUP_LAST) begin st <= S_IDLE; ph <= '0; end
          else ph <= ph + 1'b1;
        end
        S_IDLE: begin
          ph <= '0;
          if (go) st <= S_CSETUP;
        end
        S_CSETUP: begin
          if (ph == CSR_LAST) begin st <= S_RLOW; ph <= '0; end
          else ph <= ph + 1'b1;
        end
        S_RLOW: begin
          if (ph == RAS_LAST) begin st <= S_PRECH; ph <= '0; end
          else ph <= ph + 1'b1;
        end
        S_PRECH: begin
          if (ph == RP_LAST) begin
            st <= S_IDLE;
            ph <= '0;
            if (!init_done) begin
              init_cnt <= init_cnt + 1'b1;
              if (init_cnt == INIT_LAST) init_done <= 1'b1;
            end
          end else ph <= ph + 1'b1;
        end
        default: begin st <= S_IDLE; ph <= '0; end
      endcase
    end
  end

  // independent watch on how long the row strobe has been low
  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_lo_run <= '0;
    else if (ras_lo_run != RW'(RAS_MAX_CYC)) ras_lo_run <= ras_lo_run + 1'b1;
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R5
  AST_RAS_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_lo_run < RW'(RAS_MAX_CYC))); // R6
  AST_GNT_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && st == S_IDLE && !(pending && bus_gnt)) |=> (st != S_CSETUP)); // R8
  AST_CAS_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n); // R5

endmodule

// File: rtl/cbr_refresh_sched.sv
`timescale 1ns/1ps
module cbr_refresh_sched #(
  parameter int CLK_NS          = 10,
  parameter int PWRUP_NS        = 100000,
  parameter int REF_INTERVAL_NS = 15600,
  parameter int CSR_NS          = 10,
  parameter int RAS_MIN_NS      = 60,
  parameter int RAS_MAX_NS      = 10000,
  parameter int RP_NS           = 40,
  parameter int RC_NS           = 110,
  parameter int INIT_REFS       = 8,
  parameter int MAX_PEND        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic refresh_req,
  output logic refresh_urgent,
  output logic ref_active,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic backlog_err
);
  import cbr_pkg::*;

  localparam int PWRUP_CYC    = max_i(1, ceil_div(PWRUP_NS, CLK_NS));
  localparam int INTERVAL_CYC = max_i(2, REF_INTERVAL_NS / CLK_NS);
  localparam int CSR_CYC      = max_i(1, ceil_div(CSR_NS, CLK_NS));
  localparam int RP_CYC       = max_i(1, ceil_div(RP_NS, CLK_NS));
  localparam int RAS_MAX_CYC  = max_i(2, RAS_MAX_NS / CLK_NS);
  localparam int RAS_CYC      = max_i(1, min_i(max_i(ceil_div(RAS_MIN_NS, CLK_NS),
                                                     ceil_div(RC_NS, CLK_NS) - RP_CYC),
                                               RAS_MAX_CYC - 1));

  logic tick, pending, ref_done, idle, owed_done;

  assign owed_done   = ref_done && init_done;
  assign refresh_req = init_done && pending && idle;

  cbr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(init_done), .tick(tick)
  );

  cbr_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .done(owed_done),
    .pending(pending), .urgent(refresh_urgent), .overflow_err(backlog_err)
  );

  cbr_strobe_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC),
    .RP_CYC(RP_CYC), .RAS_MAX_CYC(RAS_MAX_CYC), .INIT_REFS(INIT_REFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .bus_gnt(bus_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .ref_active(ref_active),
    .ref_done(ref_done), .idle(idle), .init_done(init_done)
  );

  AST_INIT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req); // R4
  AST_STROBES_ONLY_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ref_active); // R2

endmodule

// File: tb/tb_cbr_refresh_sched.sv
`timescale 1ns/1ps
module tb_cbr_refresh_sched;
  localparam int CLK_PERIOD = 10;
  // bench-side timing, worked out by hand from the bench parameters below
  localparam int P    = 50;        // 500 ns pause / 10 ns
  localparam int CSR  = 1;         // 10 ns CAS lead
  localparam int RASW = 7;         // larger of 60/10 and 110/10-4
  localparam int RP   = 4;         // 40 ns precharge
  localparam int INTV = 60;        // 600 ns interval
  localparam int NINIT = 8;
  localparam int PER  = CSR + RASW + RP + 1;               // 13
  localparam int FIRST_FALL = P + 1 + CSR;                 // 52
  localparam int D = FIRST_FALL + (NINIT - 1) * PER + RASW + RP; // init_done cycle

  logic clk = 1'b0, rst_n = 1'b0, bus_gnt = 1'b0;
  logic refresh_req, refresh_urgent, ref_active, ras_n, cas_n, init_done, backlog_err;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  cbr_refresh_sched #(
    .CLK_NS(10), .PWRUP_NS(500), .REF_INTERVAL_NS(600), .CSR_NS(10),
    .RAS_MIN_NS(60), .RAS_MAX_NS(10000), .RP_NS(40), .RC_NS(110),
    .INIT_REFS(NINIT), .MAX_PEND(3)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .refresh_req(refresh_req),
    .refresh_urgent(refresh_urgent), .ref_active(ref_active), .ras_n(ras_n),
    .cas_n(cas_n), .init_done(init_done), .backlog_err(backlog_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_ref(input int c);
    exp_q.push_back(c);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // monitor: pops expected RAS-fall cycles and measures strobe timing
  bit prev_ras = 1'b1, prev_cas = 1'b1, seen_ref = 1'b0, cas_bad = 1'b0;
  int cas_lo_run = 0, ras_lo_run = 0, hi_run = 0, first_cas_fall = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cas && !cas_n) begin
        if (first_cas_fall < 0) first_cas_fall = cyc;
        if (seen_ref) chk(hi_run >= RP, "R7", "precharge before CAS fall", hi_run, RP);
      end
      if (ras_n && !cas_n) cas_lo_run++;
      else if (ras_n) cas_lo_run = 0;
      if (prev_ras && !ras_n) begin
        chk(cas_lo_run == CSR, "R5", "CAS lead before RAS", cas_lo_run, CSR);
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected RAS fall at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R3", "RAS fall cycle", cyc, e);
        end
        ras_lo_run = 0;
        cas_bad = 1'b0;
      end
      if (!ras_n) begin
        ras_lo_run++;
        if (cas_n) cas_bad = 1'b1;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo_run == RASW, "R6", "RAS low width", ras_lo_run, RASW);
        chk(!cas_bad && cas_n, "R5", "CAS low through RAS and rising with it", int'(cas_bad), 0);
        seen_ref = 1'b1;
        hi_run = 0;
      end
      if (ras_n && cas_n) hi_run++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ras_n === 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(cas_n === 1'b1, "R1", "cas_n in reset", cas_n, 1);
    chk(init_done === 1'b0, "R1", "init_done in reset", init_done, 0);
    chk(refresh_req === 1'b0, "R1", "refresh_req in reset", refresh_req, 0);
    chk(refresh_urgent === 1'b0, "R1", "urgent in reset", refresh_urgent, 0);
    chk(backlog_err === 1'b0, "R1", "backlog_err in reset", backlog_err, 0);
    for (int i = 0; i < NINIT; i++) push_ref(FIRST_FALL + i * PER);
    rst_n = 1'b1;

    wait_cyc(P);
    chk(ras_n && cas_n, "R2", "strobes high at end of pause", int'({ras_n, cas_n}), 3);
    wait_cyc(D - 1);
    chk(init_done == 1'b0, "R4", "init_done before last precharge ends", init_done, 0);
    chk(refresh_req == 1'b0, "R4", "refresh_req held off during init", refresh_req, 0);
    wait_cyc(D);
    chk(init_done == 1'b1, "R4", "init_done rise cycle", init_done, 1);
    chk(first_cas_fall == P + 1, "R2", "first CAS fall cycle", first_cas_fall, P + 1);
    chk(exp_q.size() == 0, "R3", "init refreshes outstanding", exp_q.size(), 0);

    // grant always available: refreshes follow the interval exactly
    bus_gnt = 1'b1;
    for (int j = 1; j <= 3; j++) push_ref(D + j * INTV + CSR + 1);
    wait_cyc(D + INTV - 1);
    chk(refresh_req == 1'b0, "R8", "no request before first interval", refresh_req, 0);
    wait_cyc(D + INTV);
    chk(refresh_req == 1'b1, "R8", "request at first interval", refresh_req, 1);
    wait_cyc(D + 200);
    chk(exp_q.size() == 0, "R8", "periodic refreshes outstanding", exp_q.size(), 0);
    bus_gnt = 1'b0;

    // grant withheld: backlog builds to full
    wait_cyc(D + 4 * INTV + 1);
    chk(refresh_req == 1'b1, "R9", "request held while ungranted", refresh_req, 1);
    chk(refresh_urgent == 1'b0, "R9", "urgent with one owed", refresh_urgent, 0);
    wait_cyc(D + 6 * INTV - 10);
    chk(refresh_urgent == 1'b0, "R9", "urgent with two owed", refresh_urgent, 0);
    wait_cyc(D + 6 * INTV + 1);
    chk(refresh_urgent == 1'b1, "R9", "urgent with backlog full", refresh_urgent, 1);
    chk(backlog_err == 1'b0, "R11", "no error at full backlog", backlog_err, 0);
    chk(ras_n == 1'b1, "R8", "no refresh without grant", ras_n, 1);

    // grant given: three owed refreshes run back to back
    wait_cyc(D + 6 * INTV + 5);
    for (int k = 0; k < 3; k++) push_ref(D + 6 * INTV + 5 + CSR + 1 + k * PER);
    bus_gnt = 1'b1;
    wait_cyc(D + 6 * INTV + 50);
    chk(exp_q.size() == 0, "R10", "drained refreshes outstanding", exp_q.size(), 0);
    chk(refresh_req == 1'b0, "R10", "request after drain", refresh_req, 0);
    chk(refresh_urgent == 1'b0, "R10", "urgent after drain", refresh_urgent, 0);
    bus_gnt = 1'b0;

    // grant withheld one interval past full: sticky overflow
    wait_cyc(D + 10 * INTV - 2);
    chk(refresh_urgent == 1'b1, "R9", "urgent before overflow", refresh_urgent, 1);
    chk(backlog_err == 1'b0, "R11", "error before overflow", backlog_err, 0);
    wait_cyc(D + 10 * INTV + 2);
    chk(backlog_err == 1'b1, "R11", "error after overflow", backlog_err, 1);
    wait_cyc(D + 10 * INTV + 50);
    chk(backlog_err == 1'b1, "R11", "error sticky", backlog_err, 1);
    chk(refresh_urgent == 1'b1, "R11", "backlog stays full", refresh_urgent, 1);
    chk(exp_q.size() == 0, "R8", "no extra refresh expected", exp_q.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule